// File: doc/BRIEF.md
# Sprite Memory Page Copy Engine

This block is a small bus master that moves one page of processor memory into a sprite-memory data port. The processor starts it by writing a page number to a trigger register. The engine then stalls the processor and takes over the bus. Byte by byte, it reads from consecutive source addresses inside the chosen page. Each byte it reads is written, in the next cycle, to a single fixed destination address. When the last byte has been written, the engine releases the processor and pulses a completion flag.

One clock of the block equals one processor cycle. Before the first read, the engine inserts alignment cycles, in which it holds the processor but does not use the bus. The number of these cycles depends on an input that reports the parity of the cycle in which the trigger write arrived. The total stall is therefore 513 or 514 cycles.

Top module: `spr_dma`

## Requirements
- R1: After reset, `cpu_halt`, `bus_req` and `xfer_done` are all low.
- R2: A write strobe whose address equals the trigger address (default 0x4014) starts a transfer, and `cpu_halt` rises in the next cycle. A write to any other address leaves the engine idle.
- R3: A trigger that arrives while `cyc_odd` is 1 gives exactly one alignment cycle, which makes 513 consecutive cycles of `cpu_halt` high.
- R4: A trigger that arrives while `cyc_odd` is 0 gives exactly two alignment cycles, which makes 514 consecutive cycles of `cpu_halt` high.
- R5: Read cycles (`bus_req`=1, `bus_rnw`=1) place the written page number in address bits 15:8 and a byte index in bits 7:0. The index runs 0x00, 0x01, … 0xFF in ascending order.
- R6: Every write cycle (`bus_req`=1, `bus_rnw`=0) drives the destination address (default 0x2004). Its `bus_wdata` equals the `bus_rdata` value returned in the read cycle just before it.
- R7: During the alignment cycles `bus_req` is low. After that the bus strictly alternates one read and one write, starting with a read, for 256 pairs. `bus_req` is never high while `cpu_halt` is low.
- R8: A trigger write that arrives while a transfer is running is ignored. The running transfer keeps its page and its length.
- R9: `xfer_done` is high for exactly one cycle: the first cycle after the last write, in which `cpu_halt` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Processor register write strobe |
| reg_addr | input | 16 | Address of the register write |
| reg_wdata | input | 8 | Data of the register write (the page number) |
| cyc_odd | input | 1 | 1 when the current processor cycle is odd |
| cpu_halt | output | 1 | Stalls the processor while a transfer runs |
| bus_req | output | 1 | Engine drives the bus this cycle |
| bus_rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data returned by memory in the same cycle |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: a 16-bit address, an 8-bit byte index (so 256-byte pages), trigger address 0x4014 and destination 0x2004. These values make the full-length transfer and the index wrap from 0xFF reachable, so page 0x00 and page 0xFF can both be driven as directed corner cases next to random pages and parities. Memory is modelled as a function of the address, which lets each written byte be traced back to its source index and shows the order in which bytes arrive.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_READ  = 2'd2,
      ST_WRITE = 2'd3
   } dma_state_e;

   // number of alignment cycles for a given trigger parity
   function automatic int unsigned align_cycles(input logic odd);
      return odd ? 1 : 2;
   endfunction

endpackage

// File: rtl/spr_dma_trig.sv
module spr_dma_trig #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAGE_W    = 8,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              busy,
   output logic              start,
   output logic [PAGE_W-1:0] page_q
);

   logic hit;

   assign hit   = reg_wr && (reg_addr == TRIG_ADDR);
   // writes while busy are dropped so the running page stays intact
   assign start = hit && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (start) begin
         page_q <= reg_wdata[PAGE_W-1:0];
      end
   end

endmodule

// File: rtl/spr_dma_idx.sv
module spr_dma_idx #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] idx,
   output logic             last
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (inc) begin
         idx <= idx + 1'b1;   // wraps to zero after the final byte
      end
   end

   assign last = &idx;

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
   import spr_dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic odd,
   input  logic last,
   output logic busy,
   output logic rd_cyc,
   output logic wr_cyc,
   output logic done
);

   dma_state_e state;
   logic       extra;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         extra <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_ALIGN;
                  extra <= (align_cycles(odd) == 2);
               end
            end
            ST_ALIGN: begin
               if (extra) begin
                  extra <= 1'b0;
               end else begin
                  state <= ST_READ;
               end
            end
            ST_READ: begin
               state <= ST_WRITE;
            end
            ST_WRITE: begin
               if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_READ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign rd_cyc = (state == ST_READ);
   assign wr_cyc = (state == ST_WRITE);

endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 8,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
   parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              cyc_odd,
   output logic              cpu_halt,
   output logic              bus_req,
   output logic              bus_rnw,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              xfer_done
);

   localparam int unsigned PAGE_W = ADDR_W - IDX_W;

   generate
      if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
         $error("spr_dma: IDX_W must be between 1 and ADDR_W-1");
      end
      if (PAGE_W > DATA_W) begin : g_bad_page
         $error("spr_dma: page number must fit in one register write");
      end
   endgenerate

   logic              start;
   logic              busy;
   logic              rd_cyc;
   logic              wr_cyc;
   logic              last;
   logic [PAGE_W-1:0] page_q;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] byte_q;

   spr_dma_trig #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .TRIG_ADDR(TRIG_ADDR)
   ) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .busy     (busy),
      .start    (start),
      .page_q   (page_q)
   );

   spr_dma_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .odd   (cyc_odd),
      .last  (last),
      .busy  (busy),
      .rd_cyc(rd_cyc),
      .wr_cyc(wr_cyc),
      .done  (xfer_done)
   );

   spr_dma_idx #(
      .IDX_W(IDX_W)
   ) u_idx (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start),
      .inc  (wr_cyc),
      .idx  (idx),
      .last (last)
   );

   // holding register between the read and the write of one byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (rd_cyc) begin
         byte_q <= bus_rdata;
      end
   end

   assign cpu_halt  = busy;
   assign bus_req   = rd_cyc || wr_cyc;
   assign bus_rnw   = !wr_cyc;
   assign bus_addr  = wr_cyc ? DEST_ADDR : {page_q, idx};
   assign bus_wdata = wr_cyc ? byte_q : '0;

endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 8,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
   parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              cyc_odd,
   input logic              cpu_halt,
   input logic              bus_req,
   input logic              bus_rnw,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              xfer_done
);

   localparam int unsigned NBYTES = 1 << IDX_W;
   localparam int unsigned CW     = IDX_W + 2;

   logic          odd_q;
   logic [CW-1:0] hcnt;
   logic          hit;

   assign hit = reg_wr && (reg_addr == TRIG_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         odd_q <= 1'b0;
         hcnt  <= '0;
      end else begin
         if (!cpu_halt && hit) odd_q <= cyc_odd;
         hcnt <= cpu_halt ? hcnt + 1'b1 : '0;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !cpu_halt && !bus_req && !xfer_done);

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_halt && hit) |=> cpu_halt);

   p_stay_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_halt && !hit) |=> !cpu_halt);

   p_len_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_halt) && odd_q) |-> hcnt == CW'(2 * NBYTES + 1));

   p_len_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_halt) && !odd_q) |-> hcnt == CW'(2 * NBYTES + 2));

   p_first_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_rnw && !$past(bus_req)) |-> bus_addr[IDX_W-1:0] == '0);

   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_rnw && $past(bus_req, 2) && $past(bus_rnw, 2))
      |-> bus_addr == $past(bus_addr, 2) + 1'b1);

   p_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rnw) |-> bus_addr == DEST_ADDR);

   p_wdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rnw) |-> bus_wdata == $past(bus_rdata));

   p_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_rnw) |=> bus_req && !bus_rnw);

   p_bus_in_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> cpu_halt);

   p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_rnw && $past(bus_req, 2) && $past(bus_rnw, 2))
      |-> bus_addr[ADDR_W-1:IDX_W] == $past(bus_addr[ADDR_W-1:IDX_W], 2));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !cpu_halt && $past(bus_req && !bus_rnw));

   p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

endmodule

bind spr_dma spr_dma_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .TRIG_ADDR(TRIG_ADDR),
   .DEST_ADDR(DEST_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .cyc_odd  (cyc_odd),
   .cpu_halt (cpu_halt),
   .bus_req  (bus_req),
   .bus_rnw  (bus_rnw),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .xfer_done(xfer_done)
);

// File: tb/spr_dma_test.sv
`timescale 1ns/1ps
module spr_dma_test;

   localparam logic [15:0] TRIG = 16'h4014;
   localparam logic [15:0] DEST = 16'h2004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        cyc_odd = 1'b0;
   logic        cpu_halt;
   logic        bus_req;
   logic        bus_rnw;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        xfer_done;

   int errors = 0;
   int checks = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return (a[7:0] * 8'd7 + a[15:8]) ^ 8'h5A;
   endfunction

   assign bus_rdata = mem_byte(bus_addr);

   spr_dma uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .cyc_odd  (cyc_odd),
      .cpu_halt (cpu_halt),
      .bus_req  (bus_req),
      .bus_rnw  (bus_rnw),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .xfer_done(xfer_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // one full transfer; inject>0 fires a second trigger in that halt cycle
   task automatic run_xfer(input logic [7:0] page, input bit odd, input int inject);
      int  halt_n  = 0;
      int  dummy   = 0;
      int  idx     = 0;
      bit  want_rd = 1'b1;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = TRIG; reg_wdata = page; cyc_odd = odd;
      @(negedge clk);
      reg_wr = 1'b0; cyc_odd = ~odd;
      check(cpu_halt === 1'b1, "R2 halt after trigger", cpu_halt, 1);
      for (int guard = 0; guard < 700; guard++) begin
         if (!cpu_halt) break;
         halt_n++;
         if (!bus_req) begin
            dummy++;
            check(idx == 0, "R7 idle bus only before transfer", idx, 0);
         end else if (bus_rnw) begin
            check(want_rd, "R7 read where write expected", 0, 1);
            check(bus_addr == {page, idx[7:0]}, "R5 read address", bus_addr, {page, idx[7:0]});
            want_rd = 1'b0;
         end else begin
            check(!want_rd, "R7 write where read expected", 1, 0);
            check(bus_addr == DEST, "R6 write address", bus_addr, DEST);
            check(bus_wdata == mem_byte({page, idx[7:0]}), "R6 byte order",
                  bus_wdata, mem_byte({page, idx[7:0]}));
            idx++;
            want_rd = 1'b1;
         end
         if (inject != 0 && halt_n == inject) begin
            reg_wr = 1'b1; reg_addr = TRIG; reg_wdata = ~page;   // R8 ignored
         end else begin
            reg_wr = 1'b0;
         end
         @(negedge clk);
      end
      reg_wr = 1'b0;
      if (odd) begin
         check(halt_n == 513, "R3 halt length odd", halt_n, 513);
         check(dummy == 1, "R3 alignment cycles", dummy, 1);
      end else begin
         check(halt_n == 514, "R4 halt length even", halt_n, 514);
         check(dummy == 2, "R4 alignment cycles", dummy, 2);
      end
      check(idx == 256, "R5 byte count", idx, 256);
      if (inject != 0) check(idx == 256, "R8 transfer unchanged by retrigger", idx, 256);
      check(xfer_done === 1'b1, "R9 done after last write", xfer_done, 1);
      check(bus_req === 1'b0, "R7 bus free after transfer", bus_req, 0);
      @(negedge clk);
      check(xfer_done === 1'b0, "R9 done one cycle", xfer_done, 0);
      check(cpu_halt === 1'b0, "R9 stays idle", cpu_halt, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20251);
      repeat (3) @(negedge clk);
      // R1 reset state
      check(cpu_halt === 1'b0, "R1 halt at reset", cpu_halt, 0);
      check(bus_req === 1'b0, "R1 bus_req at reset", bus_req, 0);
      check(xfer_done === 1'b0, "R1 done at reset", xfer_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cpu_halt === 1'b0, "R1 idle after reset", cpu_halt, 0);

      // R2 write to a neighbour register does nothing
      reg_wr = 1'b1; reg_addr = TRIG + 16'd1; reg_wdata = 8'h33;
      @(negedge clk);
      reg_wr = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check(cpu_halt === 1'b0 && bus_req === 1'b0, "R2 other address ignored", cpu_halt, 0);
         @(negedge clk);
      end

      // directed corners
      run_xfer(8'h00, 1'b1, 0);
      run_xfer(8'hFF, 1'b0, 0);
      run_xfer(8'h02, 1'b1, 100);   // R8 retrigger mid-transfer
      run_xfer(8'h80, 1'b0, 1);     // R8 retrigger in alignment cycle

      // random pages and parities
      for (int n = 0; n < 6; n++) begin
         run_xfer(8'($urandom), 1'($urandom), (($urandom % 3) == 0) ? 1 + int'($urandom % 500) : 0);
      end

      finish_run();
   end

endmodule